// File: doc/BRIEF.md
# Posted Write Line Buffer

This block sits between an expansion bus and PCI and gathers posted memory writes bound for PCI into one 16-byte line. The line carries a tag made from the upper address bits and one valid flag per byte. Later writes to the same line merge byte by byte, and a newer byte replaces an older one. The line goes out as a single PCI memory-write burst when one of these happens: every byte becomes valid, a write arrives for a different line, or the buffer-management logic asks for a flush.

When the buffer is switched off, each write goes out at once as its own single-dword PCI write. The PCI side is reduced to three handshakes: a request/grant pair that wins the bus, a one-cycle address phase, and data phases that move forward on a per-dword accept from the target. Bursts always run in linear incrementing order. If no target claims the cycle within the device-select window, the burst ends in master abort, the line is dropped, and a one-cycle status pulse reports the abort.

Top module: `wlb_posted_line_buf`

## Requirements
- R1: After reset, `req_o`, `addr_vld_o`, `dat_vld_o` and `abort_o` are low, `wr_ready_o` is high and the line is empty.
- R2: With the buffer enabled, accepted writes to the line that is currently open merge per byte, and a later byte overrides an earlier one. In a data phase, byte lane k of `dat_o` (bits 8k+7..8k) carries the stored byte when `be_o[k]` is 1 and reads 0 otherwise.
- R3: When an accepted write leaves all 16 bytes valid, `req_o` rises in the next cycle.
- R4: A write with nonzero byte enables whose address bits [31:4] differ from the tag of a non-empty line is held off (`wr_ready_o` low), the old line is flushed, and the write is then accepted into a fresh line.
- R5: `flush_req_i` high while idle flushes a non-empty line. On an empty line it has no effect, and no request is raised.
- R6: With `buf_en_i` low, each accepted write with nonzero enables becomes its own one-dword burst. A line that still holds data when the buffer is turned off is flushed before any new write is accepted.
- R7: The address phase is the single cycle after the cycle in which `req_o` and `gnt_i` are both high. `addr_o` equals the line base plus 4 times the index of the lowest dword that has valid bytes, and bits [1:0] are 00. The data phases cover the dwords from the lowest valid dword to the highest one in increasing order. A dword inside that span with no valid bytes goes out with `be_o`=0. `last_o` marks the final dword.
- R8: A data phase advances on `ack_i` only once `devsel_i` has been seen, either in the same cycle or earlier in the burst.
- R9: If `devsel_i` stays low for DEVSEL_WIN data cycles, `abort_o` pulses for one cycle in the next cycle, the burst stops and the line is discarded.
- R10: `wr_ready_o` is low from the start of a burst until the line has drained, and also while `flush_req_i` is high.
- R11: A write with all byte enables low is accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_en_i | input | 1 | 1 = gather writes into the line, 0 = flow-through |
| wr_valid_i | input | 1 | Incoming write is valid |
| wr_ready_o | output | 1 | Incoming write is accepted this cycle |
| wr_addr_i | input | ADDR_W | Write byte address (bits [1:0] ignored) |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Write byte enables, active high |
| flush_req_i | input | 1 | Buffer-management flush request |
| req_o | output | 1 | PCI bus request |
| gnt_i | input | 1 | PCI bus grant |
| addr_vld_o | output | 1 | Address phase |
| addr_o | output | ADDR_W | Burst start address, bits [1:0] = 00 |
| dat_vld_o | output | 1 | Data phase |
| dat_o | output | 32 | Data of the current dword |
| be_o | output | 4 | Byte enables of the current dword, active high |
| last_o | output | 1 | Current dword is the last in the burst |
| devsel_i | input | 1 | Target has claimed the cycle |
| ack_i | input | 1 | Target accepts the current dword |
| abort_o | output | 1 | One-cycle master-abort pulse |

## Verification
The bench drives inputs just after a rising edge, compares every output at the falling edge, and advances its own model at the rising edge, so each result is checked in the cycle the requirements set for it. Counting from a triggering accept or an idle flush request, `req_o` is due one cycle later. The address phase follows one cycle after the grant cycle, and the first data phase follows one cycle after that. Each accepted dword moves the burst on in the next cycle, and `abort_o` comes one cycle after the last cycle of the device-select window. Whole scenarios are also checked by counting address phases and abort pulses against hand-derived totals.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA
  } wlb_state_e;
endpackage

// File: rtl/wlb_line_store.sv
module wlb_line_store #(
  parameter int unsigned DW_N  = 4,
  parameter int unsigned OFF_W = 2,
  parameter int unsigned TAG_W = 28
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       fresh_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic [OFF_W-1:0]           wr_dw_i,
  input  logic [wlb_pkg::DATA_W-1:0] wr_data_i,
  input  logic [wlb_pkg::BE_W-1:0]   wr_be_i,
  input  logic                       clr_i,
  input  logic                       busy_i,
  input  logic [OFF_W-1:0]           rd_dw_i,
  output logic [TAG_W-1:0]           tag_o,
  output logic                       valid_o,
  output logic                       full_next_o,
  output logic [OFF_W-1:0]           first_o,
  output logic [OFF_W-1:0]           last_o,
  output logic [wlb_pkg::DATA_W-1:0] rd_data_o,
  output logic [wlb_pkg::BE_W-1:0]   rd_be_o
);
  import wlb_pkg::*;

  logic [DW_N-1:0][DATA_W-1:0] data_q;
  logic [DW_N-1:0][BE_W-1:0]   be_q, be_merge;
  logic [TAG_W-1:0]            tag_q;
  logic [DW_N-1:0]             dw_any;
  logic                        found;

  always_comb begin
    for (int d = 0; d < DW_N; d++) begin
      be_merge[d] = fresh_i ? '0 : be_q[d];
      if (OFF_W'(d) == wr_dw_i) be_merge[d] = be_merge[d] | wr_be_i;
      dw_any[d] = |be_q[d];
    end
  end

  assign full_next_o = &be_merge;
  assign valid_o     = |dw_any;
  assign tag_o       = tag_q;

  // span of dwords holding valid bytes
  always_comb begin
    first_o = '0;
    last_o  = '0;
    found   = 1'b0;
    for (int d = 0; d < DW_N; d++) begin
      if (dw_any[d] && !found) begin
        first_o = OFF_W'(d);
        found   = 1'b1;
      end
      if (dw_any[d]) last_o = OFF_W'(d);
    end
  end

  always_comb begin
    rd_be_o = be_q[rd_dw_i];
    for (int b = 0; b < BE_W; b++)
      rd_data_o[8*b +: 8] = rd_be_o[b] ? data_q[rd_dw_i][8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q  <= '0;
      tag_q <= '0;
    end else if (clr_i) begin
      be_q <= '0;
    end else if (wr_i) begin
      be_q <= be_merge;
      if (fresh_i) tag_q <= wr_tag_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      for (int b = 0; b < BE_W; b++)
        if (wr_be_i[b]) data_q[wr_dw_i][8*b +: 8] <= wr_data_i[8*b +: 8];
    end
  end

  // line contents frozen while a burst drains
  a_r10_line_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clr_i) |=> $stable(be_q));

  a_r11_empty_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o);
endmodule

// File: rtl/wlb_burst_seq.sv
module wlb_burst_seq #(
  parameter int unsigned OFF_W      = 2,
  parameter int unsigned DEVSEL_WIN = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OFF_W-1:0] first_i,
  input  logic [OFF_W-1:0] last_i,
  input  logic             gnt_i,
  input  logic             devsel_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             req_o,
  output logic             addr_vld_o,
  output logic             dat_vld_o,
  output logic             last_o,
  output logic [OFF_W-1:0] cur_o,
  output logic             clear_o,
  output logic             abort_o
);
  import wlb_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEVSEL_WIN + 1);

  wlb_state_e       st_q;
  logic [OFF_W-1:0] cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q, abort_q;
  logic             claimed, adv, timeout;

  assign busy_o     = (st_q != ST_IDLE);
  assign req_o      = (st_q == ST_REQ);
  assign addr_vld_o = (st_q == ST_ADDR);
  assign dat_vld_o  = (st_q == ST_DATA);
  assign cur_o      = cur_q;
  assign last_o     = dat_vld_o && (cur_q == last_i);
  assign claimed    = seen_q || devsel_i;
  assign adv        = dat_vld_o && claimed && ack_i;
  assign timeout    = dat_vld_o && !claimed && (cnt_q == CNT_W'(DEVSEL_WIN - 1));
  assign clear_o    = (adv && last_o) || timeout;
  assign abort_o    = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= timeout;
      unique case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_REQ;
        ST_REQ:  if (gnt_i) st_q <= ST_ADDR;
        ST_ADDR: begin
          st_q   <= ST_DATA;
          cur_q  <= first_i;
          cnt_q  <= '0;
          seen_q <= 1'b0;
        end
        ST_DATA: begin
          if (devsel_i) seen_q <= 1'b1;
          if (!claimed) cnt_q <= cnt_q + 1'b1;
          if (timeout) st_q <= ST_IDLE;
          else if (adv) begin
            if (cur_q == last_i) st_q <= ST_IDLE;
            else cur_q <= cur_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r7_addr_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> $past(req_o && gnt_i));

  a_r7_cur_in_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_vld_o |-> (cur_o >= first_i && cur_o <= last_i));

  a_r8_hold_without_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dat_vld_o) && dat_vld_o && !$past(ack_i)) |-> $stable(cur_o));

  a_r9_abort_ends_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(dat_vld_o) && !dat_vld_o));
endmodule

// File: rtl/wlb_posted_line_buf.sv
module wlb_posted_line_buf #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned DEVSEL_WIN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_en_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        wr_be_i,
  input  logic              flush_req_i,
  output logic              req_o,
  input  logic              gnt_i,
  output logic              addr_vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dat_vld_o,
  output logic [31:0]       dat_o,
  output logic [3:0]        be_o,
  output logic              last_o,
  input  logic              devsel_i,
  input  logic              ack_i,
  output logic              abort_o
);
  localparam int unsigned DW_N  = LINE_BYTES / 4;
  localparam int unsigned OFF_W = $clog2(DW_N);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - 2;

  logic [TAG_W-1:0] wr_tag, tag_q;
  logic [OFF_W-1:0] wr_dw, first_dw, last_dw, cur_dw;
  logic             has_be, miss, line_valid, full_next, busy, clear, fresh, acc, start;

  assign wr_tag = wr_addr_i[ADDR_W-1:OFF_W+2];
  assign wr_dw  = wr_addr_i[OFF_W+1:2];
  assign has_be = |wr_be_i;
  assign miss   = (wr_tag != tag_q);
  assign fresh  = !line_valid || !buf_en_i;

  assign wr_ready_o = !busy && !flush_req_i &&
                      !(line_valid && (!buf_en_i || (has_be && miss)));
  assign acc   = wr_valid_i && wr_ready_o && has_be;
  assign start = (acc && (!buf_en_i || full_next)) ||
                 (!busy && line_valid &&
                  (flush_req_i || !buf_en_i || (wr_valid_i && has_be && miss)));

  wlb_line_store #(.DW_N(DW_N), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (acc),
    .fresh_i     (fresh),
    .wr_tag_i    (wr_tag),
    .wr_dw_i     (wr_dw),
    .wr_data_i   (wr_data_i),
    .wr_be_i     (wr_be_i),
    .clr_i       (clear),
    .busy_i      (busy),
    .rd_dw_i     (cur_dw),
    .tag_o       (tag_q),
    .valid_o     (line_valid),
    .full_next_o (full_next),
    .first_o     (first_dw),
    .last_o      (last_dw),
    .rd_data_o   (dat_o),
    .rd_be_o     (be_o)
  );

  wlb_burst_seq #(.OFF_W(OFF_W), .DEVSEL_WIN(DEVSEL_WIN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .first_i    (first_dw),
    .last_i     (last_dw),
    .gnt_i      (gnt_i),
    .devsel_i   (devsel_i),
    .ack_i      (ack_i),
    .busy_o     (busy),
    .req_o      (req_o),
    .addr_vld_o (addr_vld_o),
    .dat_vld_o  (dat_vld_o),
    .last_o     (last_o),
    .cur_o      (cur_dw),
    .clear_o    (clear),
    .abort_o    (abort_o)
  );

  // linear order only: low address bits fixed at zero
  assign addr_o = {tag_q, first_dw, 2'b00};

  a_r3_full_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && buf_en_i && full_next) |=> req_o);

  a_r5_empty_flush_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !line_valid && !wr_valid_i) |=> !req_o);

  a_r4_miss_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid && buf_en_i && has_be && miss) |-> !wr_ready_o);
endmodule

// File: tb/wlb_posted_line_buf_tb.sv
module wlb_posted_line_buf_tb_top;
  localparam int WIN = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic buf_en = 1'b1, wr_valid = 1'b0, flush_req = 1'b0;
  logic [31:0] wr_addr = '0, wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic gnt = 1'b0, devsel = 1'b0, ack = 1'b0;
  logic wr_ready, req, addr_vld, dat_vld, last, abort_p;
  logic [31:0] addr, dat;
  logic [3:0] be;

  always #5 clk = ~clk;

  wlb_posted_line_buf #(.DEVSEL_WIN(WIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .buf_en_i(buf_en),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .flush_req_i(flush_req),
    .req_o(req), .gnt_i(gnt), .addr_vld_o(addr_vld), .addr_o(addr),
    .dat_vld_o(dat_vld), .dat_o(dat), .be_o(be), .last_o(last),
    .devsel_i(devsel), .ack_i(ack), .abort_o(abort_p)
  );

  int n_cmp = 0, n_bad = 0, n_addr = 0, n_abort = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: byte map, tag, phase
  bit [7:0]  mb[16];
  bit        mv[16];
  bit [27:0] mtag;
  int        mst, mcur, mcnt;
  bit        mseen, mabort;

  function automatic bit m_any();
    for (int i = 0; i < 16; i++) if (mv[i]) return 1;
    return 0;
  endfunction
  function automatic bit m_full();
    for (int i = 0; i < 16; i++) if (!mv[i]) return 0;
    return 1;
  endfunction
  function automatic bit dw_has(int d);
    return mv[4*d] | mv[4*d+1] | mv[4*d+2] | mv[4*d+3];
  endfunction
  function automatic int m_first();
    for (int d = 0; d < 4; d++) if (dw_has(d)) return d;
    return 0;
  endfunction
  function automatic int m_last();
    int l = 0;
    for (int d = 0; d < 4; d++) if (dw_has(d)) l = d;
    return l;
  endfunction
  function automatic bit m_ready();
    bit miss = (wr_addr[31:4] != mtag);
    return (mst == 0) && !flush_req && !(m_any() && (!buf_en || (wr_be != 0 && miss)));
  endfunction
  function automatic void m_clear();
    for (int i = 0; i < 16; i++) mv[i] = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear(); mtag = '0; mst = 0; mcur = 0; mcnt = 0; mseen = 0; mabort = 0;
    end else begin
      bit ok, nab;
      nab = 0;
      case (mst)
        0: begin
          if (wr_valid && m_ready() && wr_be != 0) begin
            int d;
            d = int'(wr_addr[3:2]);
            if (!m_any() || !buf_en) begin m_clear(); mtag = wr_addr[31:4]; end
            for (int b = 0; b < 4; b++)
              if (wr_be[b]) begin mv[4*d+b] = 1; mb[4*d+b] = wr_data[8*b +: 8]; end
            if (!buf_en || m_full()) mst = 1;
          end else if (m_any() && (flush_req || !buf_en ||
                     (wr_valid && wr_be != 0 && wr_addr[31:4] != mtag))) mst = 1;
        end
        1: if (gnt) mst = 2;
        2: begin mcur = m_first(); mcnt = 0; mseen = 0; mst = 3; end
        default: begin
          ok = mseen | devsel;
          if (devsel) mseen = 1;
          if (ok && ack) begin
            if (mcur == m_last()) begin m_clear(); mst = 0; end
            else mcur++;
          end else if (!ok) begin
            if (mcnt == WIN - 1) begin m_clear(); mst = 0; nab = 1; end
            else mcnt++;
          end
        end
      endcase
      mabort = nab;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] ed;
      logic [3:0]  eb;
      for (int b = 0; b < 4; b++) begin
        eb[b] = mv[4*mcur+b];
        ed[8*b +: 8] = eb[b] ? mb[4*mcur+b] : 8'h00;
      end
      chk(wr_ready === m_ready(), "R10 wr_ready", 32'(wr_ready), 32'(m_ready()));
      chk(req === (mst == 1), "R3 req", 32'(req), 32'(mst == 1));
      chk(addr_vld === (mst == 2), "R7 addr_vld", 32'(addr_vld), 32'(mst == 2));
      chk(dat_vld === (mst == 3), "R8 dat_vld", 32'(dat_vld), 32'(mst == 3));
      chk(abort_p === mabort, "R9 abort", 32'(abort_p), 32'(mabort));
      if (mst == 2) begin
        logic [31:0] ea;
        ea = {mtag, 2'(m_first()), 2'b00};
        chk(addr === ea, "R7 addr", addr, ea);
      end
      if (mst == 3) begin
        chk(be === eb, "R7 be", 32'(be), 32'(eb));
        chk(dat === ed, "R2 data", dat, ed);
        chk(last === (mcur == m_last()), "R7 last", 32'(last), 32'(mcur == m_last()));
      end
      if (addr_vld) n_addr++;
      if (abort_p) n_abort++;
    end
  end

  // target side
  bit [15:0] lfsr = 16'hACE1;
  bit tgt_fast = 1, tgt_dev = 1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    gnt    = tgt_fast | lfsr[1];
    devsel = tgt_dev ? (tgt_fast | lfsr[2] | lfsr[5]) : 1'b0;
    ack    = tgt_fast | lfsr[0];
  end

  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] e);
    bit r;
    @(posedge clk); #2;
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = e;
    do begin
      @(negedge clk); r = wr_ready;
      @(posedge clk);
    end while (!r);
    #2 wr_valid = 0;
  endtask

  task automatic flush();
    @(posedge clk); #2 flush_req = 1;
    @(posedge clk); #2 flush_req = 0;
  endtask

  initial begin
    int a0, ab0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready === 1 && req === 0 && addr_vld === 0 && dat_vld === 0 && abort_p === 0,
        "R1 reset outputs", {27'b0, wr_ready, req, addr_vld, dat_vld, abort_p}, 32'h10);

    // R3 full line
    a0 = n_addr;
    for (int i = 0; i < 4; i++) put(32'h100 + 4*i, 32'h11111111 * (i + 1), 4'hF);
    repeat (20) @(posedge clk);
    chk(n_addr - a0 == 1, "R3 one burst on full", n_addr - a0, 1);

    // R2 merge, R7 hole in span, R5 flush
    a0 = n_addr;
    put(32'h200, 32'hAAAA_AAAA, 4'b0011);
    put(32'h200, 32'hBBBB_BBBB, 4'b0110);
    put(32'h208, 32'hCCCC_CCCC, 4'b1000);
    repeat (3) @(posedge clk);
    chk(n_addr - a0 == 0, "R2 partial line held", n_addr - a0, 0);
    flush();
    repeat (20) @(posedge clk);
    chk(n_addr - a0 == 1, "R5 flush drains line", n_addr - a0, 1);

    // R5 empty flush
    a0 = n_addr;
    flush();
    repeat (10) @(posedge clk);
    chk(n_addr - a0 == 0, "R5 empty flush no cycle", n_addr - a0, 0);

    // R4 miss
    a0 = n_addr;
    put(32'h304, 32'h0102_0304, 4'hF);
    put(32'h40C, 32'h0506_0708, 4'hF);
    repeat (20) @(posedge clk);
    chk(n_addr - a0 == 1, "R4 miss flushes old line", n_addr - a0, 1);
    flush();
    repeat (20) @(posedge clk);
    chk(n_addr - a0 == 2, "R4 new line opened", n_addr - a0, 2);

    // R11 zero enables
    a0 = n_addr;
    put(32'h500, 32'hDEAD_BEEF, 4'b0000);
    flush();
    repeat (10) @(posedge clk);
    chk(n_addr - a0 == 0, "R11 zero-enable write no effect", n_addr - a0, 0);

    // R6 flow-through
    a0 = n_addr;
    put(32'h600, 32'h1234_5678, 4'b0001);
    @(posedge clk); #2 buf_en = 0;
    put(32'h604, 32'h1, 4'hF);
    put(32'h608, 32'h2, 4'hF);
    put(32'h60C, 32'h3, 4'b1100);
    repeat (20) @(posedge clk);
    chk(n_addr - a0 == 4, "R6 one burst per write", n_addr - a0, 4);
    #2 buf_en = 1;

    // R9 master abort
    ab0 = n_abort; a0 = n_addr;
    tgt_dev = 0;
    put(32'h700, 32'h9, 4'hF);
    flush();
    repeat (30) @(posedge clk);
    chk(n_abort - ab0 == 1, "R9 one abort pulse", n_abort - ab0, 1);
    tgt_dev = 1;
    flush();
    repeat (10) @(posedge clk);
    chk(n_addr - a0 == 1, "R9 line discarded", n_addr - a0, 1);

    // mixed traffic, R8 ack/devsel gaps
    tgt_fast = 0;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) begin @(posedge clk); #2 buf_en = ~buf_en; end
      else if (r < 10) flush();
      else if (r < 14) tgt_dev = ~tgt_dev;
      else put({26'h4 + 26'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), 2'b00},
               $urandom, 4'($urandom_range(0, 15)));
    end
    tgt_dev = 1; buf_en = 1;
    flush();
    repeat (40) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule